// File: doc/BRIEF.md
# Prescaled Rollover Timebase

This block is a shared timebase. A prescaler divides the core clock by a power-of-two divisor that is chosen from a fixed set. Each prescaled step raises a one-cycle tick strobe and moves a free-running count forward. The count returns to zero after it reaches a programmable roll value. Several waveform channels can compare against the same count and tick, and a chip normally holds three independent copies.

Divisor and roll value are applied as a pair at safe moments only. Any value is taken while the block is disabled. While it runs, a new pair is picked up when the count wraps. A period is therefore never cut short, and one full cycle of the count always lasts divisor × roll-value core cycles.

Top module: `rollTimebase`

## Requirements
- R1: With `enable` held high and an active divisor d, `tick` is high for exactly one cycle in every d. It is first high in the cycle after the d-th rising edge at which `enable` is sampled high.
- R2: A `divSel` value of 1, 2, 4, 8, 16, 32, 64 or 256 selects that value as the divisor d.
- R3: A `divSel` of 0 (the reset value), 128 or any other value not listed in R2 selects d = 1.
- R4: The count moves up by one at each tick and holds its value between ticks. After n enabled edges since enable it equals floor(n/d) mod roll, so one full count cycle lasts d × roll core cycles.
- R5: A roll value of 0 uses the full counter range, 2^ROLL_W ticks per wrap.
- R6: At an edge where `enable` is sampled low, the count clears to 0, `tick` goes low and the prescaler restarts. After re-enable, timing starts again from R1.
- R7: A divisor or roll change made while the block runs has no effect until the count wraps to 0 under the old settings. From that wrap edge onward the new pair applies. A pair set while the block is disabled applies from the first enabled edge.
- R8: After reset, `count` is 0 and `tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the timebase while high |
| divSel | input | 9 | Requested divisor value |
| rollIn | input | ROLL_W | Requested roll value (0 = full range) |
| count | output | ROLL_W | Shared count |
| tick | output | 1 | One-cycle strobe on each count step |

## Verification
The hardest case to reach is a settings change in the middle of a count cycle. The old divisor and roll must stay in force until the wrap, and the new pair must take over on that exact edge. The bench starts a run with divisor 2 and roll 5 and changes both inputs while the count is at 2. It then checks every following cycle against the old formula up to the wrap and against the new formula after it. The sweeps cover every legal divisor code, several illegal ones and every roll value of a 4-bit counter, including the full-range case.

// File: rtl/rollTimebase_pkg.sv
package rollTimebase_pkg;
  localparam int MAX_LOG  = 8;
  localparam int SKIP_LOG = 7;
  localparam int DIV_W    = MAX_LOG + 1;
  localparam int PRE_W    = MAX_LOG;
  localparam int SHIFT_W  = $clog2(MAX_LOG + 1);

  typedef struct packed {
    logic clear;
    logic advance;
  } ctlStrobes_t;

  function automatic logic [SHIFT_W-1:0] decodeDiv(input logic [DIV_W-1:0] v);
    logic [SHIFT_W-1:0] s;
    s = '0;
    for (int i = 0; i <= MAX_LOG; i++) begin
      if (i != SKIP_LOG && v == (DIV_W'(1) << i)) s = SHIFT_W'(i);
    end
    return s;
  endfunction
endpackage

// File: rtl/rollTimebase_ctrl.sv
module rollTimebase_ctrl
  import rollTimebase_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divSel,
  input  logic             atLast,
  output ctlStrobes_t      ctl,
  output logic             tick
);
  logic [SHIFT_W-1:0] actShift;
  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   divMask;
  logic               stepNow;
  logic               loadCfg;

  assign divMask     = PRE_W'((DIV_W'(1) << actShift) - DIV_W'(1));
  assign stepNow     = (preCnt == divMask);
  assign ctl.clear   = !enable;
  assign ctl.advance = enable && stepNow;
  assign loadCfg     = ctl.clear || (ctl.advance && atLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      actShift <= '0;
      tick     <= 1'b0;
    end else begin
      tick <= ctl.advance;
      if (ctl.clear || stepNow) preCnt <= '0;
      else                      preCnt <= preCnt + PRE_W'(1);
      if (loadCfg) actShift <= decodeDiv(divSel);
    end
  end

  // R1: the prescaler never passes the active divisor's last phase
  a_r1_pre_bound: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= divMask);

  // R3: the skipped divisor and out-of-set shifts never become active
  a_r3_shift_legal: assert property (@(posedge clk) disable iff (!rstN)
    (actShift != SHIFT_W'(SKIP_LOG)) && (actShift <= SHIFT_W'(MAX_LOG)));

  // R1: a tick follows an edge that advanced the count
  a_r1_tick_source: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> tick);
endmodule

// File: rtl/rollTimebase_dpath.sv
module rollTimebase_dpath
  import rollTimebase_pkg::*;
#(
  parameter int ROLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [ROLL_W-1:0] rollIn,
  output logic              atLast,
  output logic [ROLL_W-1:0] count
);
  logic [ROLL_W-1:0] actRoll;
  logic [ROLL_W-1:0] lastVal;

  assign lastVal = actRoll - ROLL_W'(1);
  assign atLast  = (count == lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      actRoll <= '0;
    end else if (ctl.clear) begin
      count   <= '0;
      actRoll <= rollIn;
    end else if (ctl.advance) begin
      if (atLast) begin
        count   <= '0;
        actRoll <= rollIn;
      end else begin
        count <= count + ROLL_W'(1);
      end
    end
  end

  // R4: the count stays below a nonzero roll value
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (actRoll != '0) |-> (count < actRoll));

  // R7: the roll value stays fixed between wraps while running
  a_r7_roll_held: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clear && !(ctl.advance && atLast)) |=> $stable(actRoll));
endmodule

// File: rtl/rollTimebase.sv
module rollTimebase
  import rollTimebase_pkg::*;
#(
  parameter int ROLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [8:0]        divSel,
  input  logic [ROLL_W-1:0] rollIn,
  output logic [ROLL_W-1:0] count,
  output logic              tick
);
  ctlStrobes_t ctl;
  logic        atLast;

  rollTimebase_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .divSel (divSel),
    .atLast (atLast),
    .ctl    (ctl),
    .tick   (tick)
  );

  rollTimebase_dpath #(.ROLL_W(ROLL_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .rollIn (rollIn),
    .atLast (atLast),
    .count  (count)
  );

  // R6: a low enable clears count and tick at the next edge
  a_r6_disabled_zero: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (count == '0 && !tick));

  // R4: no tick means the count held
  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && !tick) |-> $stable(count));

  // R4: a tick means the count stepped by one or wrapped
  a_r4_step_or_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && tick) |-> (count == $past(count) + ROLL_W'(1) || count == '0));
endmodule

// File: tb/rollTimebase_bench.sv
module rollTimebase_bench;
  localparam int PERIOD = 10;
  localparam int RW     = 4;
  localparam int FULL   = 1 << RW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic [8:0]    divSel = '0;
  logic [RW-1:0] rollIn = '0;
  logic [RW-1:0] count;
  logic          tick;

  int applied = 0;
  int failed  = 0;
  bit done    = 0;

  rollTimebase #(.ROLL_W(RW)) u_rollTimebase (
    .clk(clk), .rstN(rstN), .enable(enable), .divSel(divSel),
    .rollIn(rollIn), .count(count), .tick(tick)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int effDiv(input int code);
    if (code == 1 || code == 2 || code == 4 || code == 8 || code == 16 ||
        code == 32 || code == 64 || code == 256) return code;
    return 1;
  endfunction

  function automatic int effRoll(input int r);
    return (r == 0) ? FULL : r;
  endfunction

  task automatic check(input string req, input int expCnt, input bit expTick);
    applied++;
    if (count !== RW'(expCnt) || tick !== expTick) begin
      failed++;
      $display("FAIL %s: count=%0d tick=%0b expected count=%0d tick=%0b",
               req, count, tick, expCnt, expTick);
    end
  endtask

  task automatic stepEdge();
    @(posedge clk); #1;
  endtask

  // Disable, load a pair, enable and check n cycles against the formulas.
  task automatic runCfg(input string req, input int code, input int roll, input int cycles);
    int d, r;
    d = effDiv(code);
    r = effRoll(roll);
    enable = 1'b0; divSel = 9'(code); rollIn = RW'(roll);
    stepEdge();
    check("R6", 0, 1'b0);
    enable = 1'b1;
    for (int n = 1; n <= cycles; n++) begin
      stepEdge();
      check(req, (n / d) % r, (n % d) == 0);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failed++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  initial begin
    int codes[13] = '{0, 1, 2, 4, 8, 16, 32, 64, 256, 128, 3, 255, 511};
    // R8: reset state
    #(PERIOD * 2 + 1);
    check("R8", 0, 1'b0);
    rstN = 1'b1;
    stepEdge();
    check("R8", 0, 1'b0);

    // R2 / R3: every legal code plus illegal ones, roll 3
    foreach (codes[i]) begin
      int d;
      d = effDiv(codes[i]);
      runCfg((d == codes[i]) ? "R2" : "R3", codes[i], 3, 6 * d + 1);
    end

    // R4 / R5: every roll value with divisors 1 and 2
    for (int r = 0; r < FULL; r++) begin
      runCfg((r == 0) ? "R5" : "R4", 1, r, 2 * effRoll(r) + 2);
      runCfg((r == 0) ? "R5" : "R4", 2, r, 4 * effRoll(r) + 3);
    end
    // R5: full range with the largest divisor
    runCfg("R5", 256, 0, 256 * FULL + 5);
    // R1: divide-by-8 over a long run
    runCfg("R1", 8, 7, 8 * 7 * 3);

    // R6: disable mid-run clears and restart resumes from the start
    runCfg("R1", 4, 6, 13);
    enable = 1'b0;
    stepEdge();
    check("R6", 0, 1'b0);
    stepEdge();
    check("R6", 0, 1'b0);
    enable = 1'b1;
    for (int n = 1; n <= 10; n++) begin
      stepEdge();
      check("R6", (n / 4) % 6, (n % 4) == 0);
    end

    // R7: change while running, old pair until the wrap, new pair after
    runCfg("R7", 2, 5, 5);
    divSel = 9'd1; rollIn = RW'(3);
    for (int n = 6; n <= 10; n++) begin
      stepEdge();
      check("R7", (n / 2) % 5, (n % 2) == 0);
    end
    for (int m = 1; m <= 9; m++) begin
      stepEdge();
      check("R7", m % 3, 1'b1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule